// File: doc/BRIEF.md
# Strobed-State DMA Command Front End

This block is the command front end of a host-side DMA engine. A controlling processor talks to it over an 8-bit data bus and two active-low strobes. A falling edge on the state strobe captures a command byte, called the state. Each later falling edge on the data strobe is interpreted through that state. Depending on the state, the data strobe loads a slice of the host word address, moves one byte through the FIFO path, or reads a status byte. One state may be followed by any number of data strobes, and it stays in force until the next state strobe.

The low bits of a state are active-low function selects. Functions that do not compete for the bus can be merged into a single byte, so one data strobe can load several address slices at once. A start function in the state launches a transfer of one word or of a parameterised long block. Each beat acknowledged by the transfer engine advances the 23-bit word address by one. The block pulses `xfer_done` when the last beat is acknowledged. A state that combines conflicting functions is refused and sets a sticky error flag.

Top module: `dma_cmd_front`

## Requirements
- R1: After reset `xfer_busy`, `xfer_start`, `xfer_done`, `cmd_err`, `bus_oe`, `host_rd`, `fifo_push` and `fifo_pop` are 0 and `host_addr` is 0.
- R2: A state byte captured on a state-strobe falling edge governs every later data strobe until the next state strobe. Repeated data strobes under one state each perform that state's action again.
- R3: State bit 1 low loads `host_addr[7:0]` from the bus on each data strobe. Bit 2 low loads `host_addr[15:8]`. Bit 6 low loads `host_addr[22:16]` from bus bits 6..0 and sets `host_rd` from bus bit 7. When several of these bits are low together, one data strobe writes the same byte into every selected slice.
- R4: A legal state with bit 0 low gives a one-cycle `xfer_start` pulse and raises `xfer_busy`. Bit 5 of that state selects the length: 0 means one word, 1 means `LONG_WORDS` words.
- R5: While busy, each `beat_ack` cycle adds one to `host_addr`. The last beat of the selected length clears `xfer_busy` and pulses `xfer_done` for one cycle. A `beat_ack` while idle changes nothing.
- R6: State bit 3 low opens the FIFO path. If `host_rd` is 0, a data strobe pulses `fifo_push` once with the bus byte on `fifo_wdata`. If `host_rd` is 1, a data strobe pulses `fifo_pop` once, and `fifo_rdata` is driven on `bus_out` while the strobe is held.
- R7: State bit 4 low selects status read. While the data strobe is held, `bus_oe` is 1 and `bus_out` is {`host_rd`, 0000, error, done-flag, busy}, that is bit 7, bits 6..3, bit 2, bit 1 and bit 0. The done flag is set when a transfer ends and cleared at the next start. Outside status read and FIFO pop, `bus_oe` stays 0.
- R8: A state is illegal if it combines FIFO (bit 3 low) with status (bit 4 low), FIFO with start (bit 0 low), status with any load bit (bits 1, 2 or 6 low), or start while busy. An illegal state sets `cmd_err`, starts nothing and leaves the previous state in force. The next legal state strobe clears `cmd_err`.
- R9: A strobe held low for many cycles performs exactly one action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| state_stb_n | input | 1 | Active-low state strobe, asynchronous |
| data_stb_n | input | 1 | Active-low data strobe, asynchronous |
| bus_in | input | 8 | Data bus from the processor |
| bus_out | output | 8 | Data bus toward the processor |
| bus_oe | output | 1 | Block drives the bus |
| fifo_push | output | 1 | One-cycle push of `fifo_wdata` |
| fifo_wdata | output | 8 | Byte pushed into the FIFO |
| fifo_pop | output | 1 | One-cycle pop request |
| fifo_rdata | input | 8 | Byte at the FIFO head |
| beat_ack | input | 1 | Transfer engine finished one word |
| xfer_start | output | 1 | One-cycle transfer start |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_long | output | 1 | Current length is the long block |
| xfer_done | output | 1 | One-cycle end of transfer |
| host_addr | output | AW | Host word address counter |
| host_rd | output | 1 | 1 reads host memory, 0 writes it |
| cmd_err | output | 1 | Sticky illegal-state flag |

## Verification
The bench builds the block with `LONG_WORDS` = 4 and the default 23-bit address. With that setting a long transfer finishes within a handful of beats. This makes it affordable to sweep all 256 state bytes from an idle block, comparing the error flag and start count with a legality rule computed in the bench. Every start in the sweep is also driven to completion. Directed sequences then cover merged address loads, repeated data strobes, status contents, both FIFO directions, refusal of a start while busy, and held strobes.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    // functions a captured state applies to later data strobes
    typedef struct packed {
        logic ld_up;
        logic ld_mid;
        logic ld_low;
        logic fifo;
        logic stat;
    } dsel_t;

    // full decode of a state byte (bit 7 is not a function select)
    typedef struct packed {
        logic  go;
        logic  long_sel;
        dsel_t sel;
    } cmd_t;

    localparam dsel_t DSEL_NONE = '0;

    function automatic cmd_t decode_cmd(input logic [6:0] b);
        cmd_t c;
        c.go         = ~b[0];
        c.sel.ld_low = ~b[1];
        c.sel.ld_mid = ~b[2];
        c.sel.fifo   = ~b[3];
        c.sel.stat   = ~b[4];
        c.long_sel   = b[5];
        c.sel.ld_up  = ~b[6];
        return c;
    endfunction

    function automatic logic cmd_illegal(input cmd_t c, input logic busy);
        logic any_ld;
        any_ld = c.sel.ld_low | c.sel.ld_mid | c.sel.ld_up;
        return (c.sel.fifo & c.sel.stat) | (c.sel.fifo & c.go) |
               (c.sel.stat & any_ld) | (c.go & busy);
    endfunction

    function automatic logic [7:0] status_byte(input logic dir, input logic err,
                                               input logic dflag, input logic busy);
        return {dir, 4'b0000, err, dflag, busy};
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic stb_n,
    output logic fall,
    output logic held
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 3'b111;
        else     sync_q <= {sync_q[1:0], stb_n};
    end

    assign held = ~sync_q[1];
    assign fall = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/addr_ctr.sv
module addr_ctr #(
    parameter int AW = 23
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    din,
    input  logic          ld_low,
    input  logic          ld_mid,
    input  logic          ld_up,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          dir
);
    localparam int UW = AW - 16;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            dir  <= 1'b0;
        end else if (ld_low | ld_mid | ld_up) begin
            if (ld_low) addr[7:0]  <= din;
            if (ld_mid) addr[15:8] <= din;
            if (ld_up) begin
                addr[AW-1:16] <= din[UW-1:0];
                dir           <= din[7];
            end
        end else if (inc) begin
            addr <= addr + AW'(1);
        end
    end
endmodule

// File: rtl/dma_cmd_front.sv
module dma_cmd_front
    import dma_cmd_pkg::*;
#(
    parameter int AW         = 23,
    parameter int LONG_WORDS = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          state_stb_n,
    input  logic          data_stb_n,
    input  logic [7:0]    bus_in,
    output logic [7:0]    bus_out,
    output logic          bus_oe,
    output logic          fifo_push,
    output logic [7:0]    fifo_wdata,
    output logic          fifo_pop,
    input  logic [7:0]    fifo_rdata,
    input  logic          beat_ack,
    output logic          xfer_start,
    output logic          xfer_busy,
    output logic          xfer_long,
    output logic          xfer_done,
    output logic [AW-1:0] host_addr,
    output logic          host_rd,
    output logic          cmd_err
);
    localparam int BW = $clog2(LONG_WORDS + 1);

    logic [1:0] stb_n_vec, fall_vec, held_vec;
    assign stb_n_vec = {data_stb_n, state_stb_n};

    for (genvar i = 0; i < 2; i++) begin : g_stb
        strobe_edge u_edge (
            .clk  (clk),
            .rst  (rst),
            .stb_n(stb_n_vec[i]),
            .fall (fall_vec[i]),
            .held (held_vec[i])
        );
    end

    logic  s_fall, d_act, d_held;
    cmd_t  nxt;
    logic  nxt_bad;
    dsel_t cur;
    logic  done_flag;
    logic  step;
    logic [BW-1:0] beat_cnt, beat_last;

    assign s_fall    = fall_vec[0];
    assign d_act     = fall_vec[1] & ~held_vec[0];
    assign d_held    = held_vec[1];
    assign nxt       = decode_cmd(bus_in[6:0]);
    assign nxt_bad   = cmd_illegal(nxt, xfer_busy);
    assign step      = xfer_busy & beat_ack;
    assign beat_last = xfer_long ? BW'(LONG_WORDS - 1) : '0;

    addr_ctr #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .din   (bus_in),
        .ld_low(d_act & cur.ld_low),
        .ld_mid(d_act & cur.ld_mid),
        .ld_up (d_act & cur.ld_up),
        .inc   (step),
        .addr  (host_addr),
        .dir   (host_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= DSEL_NONE;
            cmd_err    <= 1'b0;
            xfer_busy  <= 1'b0;
            xfer_long  <= 1'b0;
            xfer_start <= 1'b0;
            xfer_done  <= 1'b0;
            done_flag  <= 1'b0;
            beat_cnt   <= '0;
            fifo_push  <= 1'b0;
            fifo_pop   <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            xfer_start <= 1'b0;
            xfer_done  <= 1'b0;
            fifo_push  <= 1'b0;
            fifo_pop   <= 1'b0;
            if (step) begin
                if (beat_cnt == beat_last) begin
                    xfer_busy <= 1'b0;
                    xfer_done <= 1'b1;
                    done_flag <= 1'b1;
                end else begin
                    beat_cnt <= beat_cnt + BW'(1);
                end
            end
            if (s_fall) begin
                if (nxt_bad) begin
                    cmd_err <= 1'b1;
                end else begin
                    cmd_err <= 1'b0;
                    cur     <= nxt.sel;
                    if (nxt.go) begin
                        xfer_start <= 1'b1;
                        xfer_busy  <= 1'b1;
                        xfer_long  <= nxt.long_sel;
                        beat_cnt   <= '0;
                        done_flag  <= 1'b0;
                    end
                end
            end else if (d_act && cur.fifo) begin
                if (host_rd) begin
                    fifo_pop <= 1'b1;
                end else begin
                    fifo_push  <= 1'b1;
                    fifo_wdata <= bus_in;
                end
            end
        end
    end

    assign bus_oe  = d_held & (cur.stat | (cur.fifo & host_rd));
    assign bus_out = !bus_oe  ? 8'h00 :
                     cur.stat ? status_byte(host_rd, cmd_err, done_flag, xfer_busy) :
                                fifo_rdata;
endmodule

// File: rtl/dma_cmd_front_chk.sv
module dma_cmd_front_chk (
    input logic clk,
    input logic rst,
    input logic xfer_start,
    input logic xfer_busy,
    input logic xfer_done,
    input logic fifo_push,
    input logic fifo_pop,
    input logic cmd_err
);
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> xfer_busy);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !xfer_busy);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);

    p_fifo_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(fifo_push && fifo_pop));

    p_push_once_r9: assert property (@(posedge clk) disable iff (rst)
        fifo_push |=> !fifo_push);

    p_pop_once_r9: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    p_err_nostart_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_err) |-> !xfer_start);
endmodule

bind dma_cmd_front dma_cmd_front_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer_start(xfer_start),
    .xfer_busy (xfer_busy),
    .xfer_done (xfer_done),
    .fifo_push (fifo_push),
    .fifo_pop  (fifo_pop),
    .cmd_err   (cmd_err)
);

// File: tb/test_dma_cmd_front.sv
`timescale 1ns/1ps
module test_dma_cmd_front;
    localparam int AW = 23;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          state_stb_n = 1'b1;
    logic          data_stb_n = 1'b1;
    logic [7:0]    bus_in = 8'h00;
    logic [7:0]    bus_out;
    logic          bus_oe;
    logic          fifo_push;
    logic [7:0]    fifo_wdata;
    logic          fifo_pop;
    logic [7:0]    fifo_rdata = 8'h00;
    logic          beat_ack = 1'b0;
    logic          xfer_start, xfer_busy, xfer_long, xfer_done;
    logic [AW-1:0] host_addr;
    logic          host_rd;
    logic          cmd_err;

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_done = 0, n_push = 0, n_pop = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    dma_cmd_front #(.AW(AW), .LONG_WORDS(LW)) i_dma_cmd_front (
        .clk(clk), .rst(rst), .state_stb_n(state_stb_n), .data_stb_n(data_stb_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .beat_ack(beat_ack), .xfer_start(xfer_start),
        .xfer_busy(xfer_busy), .xfer_long(xfer_long), .xfer_done(xfer_done),
        .host_addr(host_addr), .host_rd(host_rd), .cmd_err(cmd_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (xfer_start) n_start++;
            if (xfer_done)  n_done++;
            if (fifo_push)  n_push++;
            if (fifo_pop)   n_pop++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic put_state(input logic [7:0] b);
        @(negedge clk);
        bus_in = b;
        state_stb_n = 1'b0;
        repeat (5) @(negedge clk);
        state_stb_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic put_data(input logic [7:0] b);
        @(negedge clk);
        bus_in = b;
        data_stb_n = 1'b0;
        repeat (5) @(negedge clk);
        data_stb_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic beat();
        @(negedge clk);
        beat_ack = 1'b1;
        @(negedge clk);
        beat_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", xfer_busy, 0);
        chk("R1 err", cmd_err, 0);
        chk("R1 addr", host_addr, 0);
        chk("R1 dir", host_rd, 0);
        chk("R1 oe", bus_oe, 0);
        chk("R1 pulses", {xfer_start, xfer_done, fifo_push, fifo_pop}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R3 merged mid+low load, then upper with direction
        put_state(8'hF9);
        put_data(8'h5A);
        chk("R3 merged", host_addr, 32'h005A5A);
        put_state(8'hBF);
        put_data(8'h83);
        chk("R3 upper", host_addr, 32'h035A5A);
        chk("R3 dir", host_rd, 1);

        // R2 repeated data strobes under one state
        put_state(8'hFD);
        put_data(8'h10);
        put_data(8'h20);
        put_data(8'h30);
        chk("R2 repeat", host_addr, 32'h035A30);

        // R4/R5 long transfer
        put_state(8'hFE);
        chk("R4 start", n_start, 1);
        chk("R4 busy", xfer_busy, 1);
        chk("R4 long", xfer_long, 1);
        for (int i = 0; i < LW - 1; i++) beat();
        chk("R5 mid busy", xfer_busy, 1);
        chk("R5 mid addr", host_addr, 32'h035A33);
        beat();
        chk("R5 end busy", xfer_busy, 0);
        chk("R5 done", n_done, 1);
        chk("R5 end addr", host_addr, 32'h035A34);
        beat();
        chk("R5 idle beat", host_addr, 32'h035A34);

        // R4 single word; R8 start while busy
        put_state(8'hDE);
        chk("R4 start2", n_start, 2);
        chk("R4 short", xfer_long, 0);
        put_state(8'hDE);
        chk("R8 busy start err", cmd_err, 1);
        chk("R8 no start", n_start, 2);
        beat();
        chk("R4 single done", n_done, 2);
        chk("R4 single idle", xfer_busy, 0);

        // R7 status read
        put_state(8'hEF);
        chk("R8 err clear", cmd_err, 0);
        @(negedge clk);
        data_stb_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 oe", bus_oe, 1);
        chk("R7 status", bus_out, 8'h82);
        data_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 oe off", bus_oe, 0);

        // R8 illegal state keeps previous state
        put_state(8'hFD);
        put_state(8'hE7);
        chk("R8 err", cmd_err, 1);
        put_data(8'h77);
        chk("R8 kept state", host_addr, 32'h035A77);
        put_state(8'hEF);
        put_state(8'hE7);
        @(negedge clk);
        data_stb_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 status err", bus_out, 8'h86);
        data_stb_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6 FIFO pop with held strobe, R9 one action
        put_state(8'hF7);
        fifo_rdata = 8'hA5;
        @(negedge clk);
        data_stb_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 pop data", bus_out, 8'hA5);
        chk("R6 pop oe", bus_oe, 1);
        data_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 one pop", n_pop, 1);

        // R6 FIFO push
        put_state(8'hBF);
        put_data(8'h01);
        chk("R3 upper2", host_addr, 32'h015A77);
        chk("R3 dir2", host_rd, 0);
        put_state(8'hF7);
        @(negedge clk);
        bus_in = 8'h3C;
        data_stb_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 push no oe", bus_oe, 0);
        data_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 one push", n_push, 1);
        chk("R6 push data", fifo_wdata, 8'h3C);
        chk("R6 no pop", n_pop, 1);

        // R8/R4 sweep of every state byte from idle
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            logic f, s, g, ld, bad;
            int s0, d0;
            b  = v[7:0];
            f  = ~b[3];
            s  = ~b[4];
            g  = ~b[0];
            ld = ~b[1] | ~b[2] | ~b[6];
            bad = (f & s) | (f & g) | (s & ld);
            s0 = n_start;
            d0 = n_done;
            put_state(b);
            chk("R8 sweep err", {b, 7'b0, cmd_err}, {b, 7'b0, bad});
            chk("R4 sweep start", n_start, s0 + ((!bad && g) ? 1 : 0));
            if (!bad && g) begin
                for (int k = 0; k < (b[5] ? LW : 1); k++) beat();
                chk("R5 sweep done", {b, 7'b0, xfer_busy}, {b, 8'h00});
                chk("R5 sweep count", n_done, d0 + 1);
            end
        end

        finish_run();
    end
endmodule